// File: doc/BRIEF.md
# Processor State Interrupt Sequencer

This block decides when a processor with four execution states must give up its current state. It then performs the context exchange that hands control to a service state. Requests arrive as one-cycle pulses, one bit per cause. Causes 3 to 6 are program-class causes. Each of them is gated by a bit of the current program mask, and a request whose mask bit is clear is discarded. Every other request, and every permitted program-class request, is latched into a flag register. A flag is only acted on when the current state's interrupt mask bit for that cause is set. Until then the flag waits, and it is never lost.

At an instruction boundary the datapath raises a strobe. If any flag is eligible, the lowest-numbered one is taken, and the sequencer runs a fixed five-cycle exchange over a single port to the saved-register storage:

1. It writes the outgoing state's counter word, which holds the location counter, the condition code and the program mask.
2. It reads the incoming state's counter word, loads the condition code and program mask from it, and clears the serviced flag.
3. It reads the incoming state's status word, loads the protection key, the decimal bit and the privileged bit from it, and writes the word back with the identity of the interrupted state. On a machine check it also writes the program indicators.
4. It writes the cause number into the incoming state's general register 15.
5. It pulses the done output.

Causes 0 to 2 are power failure, machine check (cause 1) and scratch-pad parity. These causes go to state P4, and no mask can hold them. All other causes go to state P3.

Top module: `isq_top`

## Requirements
- R1: After reset the current state is P1 (code 0). The program mask is 4'b1111, the condition code, protection key, decimal bit, privileged bit and all flags are 0, and neither the done output nor the write enable is asserted.
- R2: A request on cause 3+k (k = 0..3) while program mask bit k is 0 leaves flag 3+k unchanged.
- R3: Any other request sets its flag on the next clock edge. If a request for a cause arrives in the same cycle that cause's flag is cleared by servicing, the flag stays set.
- R4: A flag whose bit in `curIntMask` is 0 starts no sequence at a boundary and stays set. Once the mask bit is 1 it is serviced at a later boundary.
- R5: At a boundary the lowest-numbered eligible flag is taken. Causes 0 to 2 are eligible whatever the mask. At most one cause is taken per boundary, even if the boundary strobe is held.
- R6: The first exchange cycle writes address {old state, 2'b00}. The data holds the location counter in bits [23:0], the condition code in [25:24], the program mask in [29:26] and zero in [31:30].
- R7: Causes 0 to 2 switch the current state to P4 (code 3). Other causes switch it to P3 (code 2). The serviced flag is cleared.
- R8: The condition code and program mask are loaded from bits [25:24] and [29:26] of the word at {new state, 2'b00}. Key, decimal and privileged are loaded from bits [3:0], [4] and [5] of the word at {new state, 2'b01}.
- R9: The word at {new state, 2'b01} is written back with bits [7:6] set to the old state code and all other bits kept. Only for cause 1 are bits [15:8] also replaced by `progInd`.
- R10: Address {new state, 2'b10} is written with the cause number. Counting from the first clock edge at which the boundary is seen, the edges are numbered 1, 2, 3 and so on. The done output is high for one cycle only, and it rises at edge 5, the edge after this write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 16 | Request pulses, one bit per cause |
| curIntMask | input | 16 | Interrupt mask of the current state |
| instrBoundary | input | 1 | Instruction boundary strobe |
| locCounter | input | 24 | Location counter of the running state |
| progInd | input | 8 | Program indicator bits |
| rfRdata | input | 32 | Read data from saved-register storage (combinational) |
| rfAddr | output | 4 | Storage address {state, select} |
| rfWe | output | 1 | Storage write enable |
| rfWdata | output | 32 | Storage write data |
| curState | output | 2 | Current processor state |
| condCode | output | 2 | Condition code register |
| progMask | output | 4 | Program mask register |
| protKey | output | 4 | Protection key register |
| decMode | output | 1 | Decimal code bit |
| privMode | output | 1 | Privileged-mode bit |
| pendingFlags | output | 16 | Interrupt flag register |
| seqDone | output | 1 | Exchange complete pulse |

## Verification
Two actions can fall in the same cycle: latching a new request, and clearing the flag of the cause being serviced. The bench provokes this by pulsing the request for the very cause under service during the cycle that reads the incoming counter word. It then judges that the flag is still set after done, and that a second boundary services the cause again. The bench also holds the boundary strobe high through a whole exchange, with two causes pending, and judges that exactly one is taken.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int DATA_W = 32;
  localparam int STATE_W = 2;
  localparam int SEL_W = 2;
  localparam int ADDR_W = STATE_W + SEL_W;
  localparam int LC_W = 24;
  localparam int CC_LSB = 24;
  localparam int CC_W = 2;
  localparam int PM_LSB = 26;
  localparam int PM_W = 4;
  localparam int PAD_W = DATA_W - PM_LSB - PM_W;
  localparam int KEY_LSB = 0;
  localparam int KEY_W = 4;
  localparam int DEC_BIT = 4;
  localparam int PRIV_BIT = 5;
  localparam int ID_LSB = 6;
  localparam int IND_LSB = 8;
  localparam int IND_W = 8;
  localparam int MC_CAUSES = 3;
  localparam int PROG_LO = 3;
  localparam int PROG_CNT = PM_W;
  localparam int MCHECK_IDX = 1;

  localparam logic [STATE_W-1:0] ST_P1 = 2'd0;
  localparam logic [STATE_W-1:0] ST_P3 = 2'd2;
  localparam logic [STATE_W-1:0] ST_P4 = 2'd3;
  localparam logic [SEL_W-1:0] SEL_CTR = 2'd0;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_GR = 2'd2;

  typedef struct packed {
    logic latchCause;
    logic saveWord;
    logic loadCounter;
    logic loadStatus;
    logic writeGr;
    logic done;
  } seq_strobe_t;
endpackage

// File: rtl/isq_ctrl.sv
module isq_ctrl
  import isq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrBoundary,
  input  logic        anyTaken,
  output seq_strobe_t strb
);
  typedef enum logic [2:0] {S_IDLE, S_SAVE, S_LDPC, S_LDST, S_GR, S_DONE} seq_state_e;
  seq_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE: if (instrBoundary && anyTaken) stateNext = S_SAVE;
      S_SAVE: stateNext = S_LDPC;
      S_LDPC: stateNext = S_LDST;
      S_LDST: stateNext = S_GR;
      S_GR:   stateNext = S_DONE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb = '0;
    strb.latchCause  = (state == S_IDLE) && instrBoundary && anyTaken;
    strb.saveWord    = (state == S_SAVE);
    strb.loadCounter = (state == S_LDPC);
    strb.loadStatus  = (state == S_LDST);
    strb.writeGr     = (state == S_GR);
    strb.done        = (state == S_DONE);
  end

  // R6: an accepted cause is followed at once by the save write
  p_save_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchCause |=> strb.saveWord);
  // R10: done follows the register 15 write and lasts one cycle
  p_done_after_gr_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeGr |=> strb.done);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !strb.done);
  // R5: no new acceptance while an exchange runs
  p_single_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchCause |=> !strb.latchCause);
endmodule

// File: rtl/isq_dp.sv
module isq_dp
  import isq_pkg::*;
#(
  parameter int NUM_CAUSES = 16,
  localparam int CAUSE_W = $clog2(NUM_CAUSES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seq_strobe_t           strb,
  input  logic [NUM_CAUSES-1:0] reqIn,
  input  logic [NUM_CAUSES-1:0] curIntMask,
  input  logic [LC_W-1:0]       locCounter,
  input  logic [IND_W-1:0]      progInd,
  input  logic [DATA_W-1:0]     rfRdata,
  output logic                  anyTaken,
  output logic [ADDR_W-1:0]     rfAddr,
  output logic                  rfWe,
  output logic [DATA_W-1:0]     rfWdata,
  output logic [STATE_W-1:0]    curState,
  output logic [CC_W-1:0]       condCode,
  output logic [PM_W-1:0]       progMask,
  output logic [KEY_W-1:0]      protKey,
  output logic                  decMode,
  output logic                  privMode,
  output logic [NUM_CAUSES-1:0] pendingFlags
);
  localparam logic [NUM_CAUSES-1:0] MC_VEC = NUM_CAUSES'((1 << MC_CAUSES) - 1);

  logic [NUM_CAUSES-1:0] flags, progKeep, accepted, eligible, clrVec;
  logic [CAUSE_W-1:0]    causeIdx, winIdx;
  logic [STATE_W-1:0]    tgtState, oldState;
  logic [DATA_W-1:0]     statWord;

  for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_keep
    if (g >= PROG_LO && g < PROG_LO + PROG_CNT) begin : g_prog
      assign progKeep[g] = progMask[g-PROG_LO];
    end else begin : g_other
      assign progKeep[g] = 1'b1;
    end
  end

  function automatic logic [CAUSE_W-1:0] lowestSet(input logic [NUM_CAUSES-1:0] v);
    lowestSet = '0;
    for (int i = NUM_CAUSES - 1; i >= 0; i--)
      if (v[i]) lowestSet = CAUSE_W'(i);
  endfunction

  assign accepted = reqIn & progKeep;
  assign eligible = flags & (curIntMask | MC_VEC);
  assign anyTaken = |eligible;
  assign winIdx   = lowestSet(eligible);
  assign clrVec   = strb.loadCounter ? (NUM_CAUSES'(1) << causeIdx) : '0;
  assign pendingFlags = flags;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags    <= '0;
      curState <= ST_P1;
      condCode <= '0;
      progMask <= '1;
      protKey  <= '0;
      decMode  <= 1'b0;
      privMode <= 1'b0;
      causeIdx <= '0;
      tgtState <= ST_P1;
      oldState <= ST_P1;
    end else begin
      flags <= (flags & ~clrVec) | accepted;
      if (strb.latchCause) begin
        causeIdx <= winIdx;
        tgtState <= (winIdx < CAUSE_W'(MC_CAUSES)) ? ST_P4 : ST_P3;
        oldState <= curState;
      end
      if (strb.loadCounter) begin
        condCode <= rfRdata[CC_LSB +: CC_W];
        progMask <= rfRdata[PM_LSB +: PM_W];
        curState <= tgtState;
      end
      if (strb.loadStatus) begin
        protKey  <= rfRdata[KEY_LSB +: KEY_W];
        decMode  <= rfRdata[DEC_BIT];
        privMode <= rfRdata[PRIV_BIT];
      end
    end
  end

  always_comb begin
    statWord = rfRdata;
    statWord[ID_LSB +: STATE_W] = oldState;
    if (causeIdx == CAUSE_W'(MCHECK_IDX)) statWord[IND_LSB +: IND_W] = progInd;
  end

  always_comb begin
    rfAddr  = '0;
    rfWdata = '0;
    if (strb.saveWord) begin
      rfAddr  = {oldState, SEL_CTR};
      rfWdata = {{PAD_W{1'b0}}, progMask, condCode, locCounter};
    end else if (strb.loadCounter) begin
      rfAddr  = {tgtState, SEL_CTR};
    end else if (strb.loadStatus) begin
      rfAddr  = {tgtState, SEL_STAT};
      rfWdata = statWord;
    end else if (strb.writeGr) begin
      rfAddr  = {tgtState, SEL_GR};
      rfWdata = DATA_W'(causeIdx);
    end
  end
  assign rfWe = strb.saveWord | strb.loadStatus | strb.writeGr;

  // R2: a cancelled program-class request never raises its flag
  p_cancel_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqIn[PROG_LO] && !progMask[0] && !flags[PROG_LO]) |=> !flags[PROG_LO]);
  // R3: a request for a non-program cause is latched, even while being cleared
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqIn[NUM_CAUSES-1] |=> flags[NUM_CAUSES-1]);
  // R4: flags only drop in the counter-load cycle
  p_pending_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCounter |=> ((flags & $past(flags)) == $past(flags)));
  // R5: hardware-class causes beat every other cause
  p_mc_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchCause && (flags[MC_CAUSES-1:0] != '0)) |=> (causeIdx < CAUSE_W'(MC_CAUSES)));
  // R7: machine-condition causes land in P4
  p_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadCounter && causeIdx < CAUSE_W'(MC_CAUSES)) |=> (curState == ST_P4));
endmodule

// File: rtl/isq_top.sv
module isq_top
  import isq_pkg::*;
#(
  parameter int NUM_CAUSES = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CAUSES-1:0] reqIn,
  input  logic [NUM_CAUSES-1:0] curIntMask,
  input  logic                  instrBoundary,
  input  logic [LC_W-1:0]       locCounter,
  input  logic [IND_W-1:0]      progInd,
  input  logic [DATA_W-1:0]     rfRdata,
  output logic [ADDR_W-1:0]     rfAddr,
  output logic                  rfWe,
  output logic [DATA_W-1:0]     rfWdata,
  output logic [STATE_W-1:0]    curState,
  output logic [CC_W-1:0]       condCode,
  output logic [PM_W-1:0]       progMask,
  output logic [KEY_W-1:0]      protKey,
  output logic                  decMode,
  output logic                  privMode,
  output logic [NUM_CAUSES-1:0] pendingFlags,
  output logic                  seqDone
);
  seq_strobe_t strb;
  logic anyTaken;

  isq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .instrBoundary(instrBoundary),
    .anyTaken(anyTaken), .strb(strb)
  );

  isq_dp #(.NUM_CAUSES(NUM_CAUSES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqIn(reqIn),
    .curIntMask(curIntMask), .locCounter(locCounter), .progInd(progInd),
    .rfRdata(rfRdata), .anyTaken(anyTaken), .rfAddr(rfAddr), .rfWe(rfWe),
    .rfWdata(rfWdata), .curState(curState), .condCode(condCode),
    .progMask(progMask), .protKey(protKey), .decMode(decMode),
    .privMode(privMode), .pendingFlags(pendingFlags)
  );

  assign seqDone = strb.done;
endmodule

// File: tb/isq_top_tb_top.sv
module isq_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] reqIn = '0;
  logic [15:0] curIntMask = '1;
  logic        instrBoundary = 1'b0;
  logic [23:0] locCounter = '0;
  logic [7:0]  progInd = '0;
  logic [31:0] rfRdata;
  logic [3:0]  rfAddr;
  logic        rfWe;
  logic [31:0] rfWdata;
  logic [1:0]  curState, condCode;
  logic [3:0]  progMask, protKey;
  logic        decMode, privMode, seqDone;
  logic [15:0] pendingFlags;

  logic [31:0] rf [16];
  logic [31:0] expRf [16];
  logic [15:0] expFlags = '0;
  logic [1:0]  expState = 2'd0, expCc = 2'd0;
  logic [3:0]  expPm = 4'hF, expKey = 4'h0;
  logic        expDec = 1'b0, expPriv = 1'b0;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  isq_top dut_i (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .curIntMask(curIntMask),
    .instrBoundary(instrBoundary), .locCounter(locCounter), .progInd(progInd),
    .rfRdata(rfRdata), .rfAddr(rfAddr), .rfWe(rfWe), .rfWdata(rfWdata),
    .curState(curState), .condCode(condCode), .progMask(progMask),
    .protKey(protKey), .decMode(decMode), .privMode(privMode),
    .pendingFlags(pendingFlags), .seqDone(seqDone)
  );

  assign rfRdata = rf[rfAddr];
  always @(posedge clk) if (rfWe) rf[rfAddr] <= rfWdata;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] acceptVec(input logic [15:0] v, input logic [3:0] pm);
    logic [15:0] r = v;
    for (int k = 0; k < 4; k++) if (!pm[k]) r[3+k] = 1'b0;
    return r;
  endfunction

  function automatic int lowestIdx(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic reqDrive(input logic [15:0] v);
    reqIn = v;
    @(negedge clk);
    reqIn = '0;
    expFlags = expFlags | acceptVec(v, expPm);
    check(pendingFlags == expFlags, "R2 R3 flag latch with program filter", 64'(pendingFlags), 64'(expFlags));
  endtask

  task automatic service(input bit hold, input logic [15:0] collide);
    logic [15:0] elig;
    int idx, lat;
    logic [1:0] tgt, old;
    logic [31:0] st;
    elig = expFlags & (curIntMask | 16'h0007);
    locCounter = 24'($urandom);
    progInd = 8'($urandom);
    instrBoundary = 1'b1;
    @(negedge clk);
    if (!hold) instrBoundary = 1'b0;
    lat = 0;
    while (!seqDone && lat < 8) begin
      @(negedge clk);
      lat++;
      if (lat == 1) reqIn = collide;
      if (lat == 2) reqIn = '0;
    end
    instrBoundary = 1'b0;
    if (elig == '0) begin
      check(seqDone == 1'b0, "R4 masked flag starts no sequence", 64'(seqDone), 64'(0));
      check(curState == expState, "R4 state kept while pending", 64'(curState), 64'(expState));
      check(pendingFlags == expFlags, "R4 flags kept pending", 64'(pendingFlags), 64'(expFlags));
      return;
    end
    idx = lowestIdx(elig);
    tgt = (idx < 3) ? 2'd3 : 2'd2;
    old = expState;
    expRf[{old, 2'b00}] = {2'b00, expPm, expCc, locCounter};
    expCc = expRf[{tgt, 2'b00}][25:24];
    expPm = expRf[{tgt, 2'b00}][29:26];
    expState = tgt;
    expFlags[idx] = 1'b0;
    expFlags = expFlags | collide;
    st = expRf[{tgt, 2'b01}];
    expKey = st[3:0];
    expDec = st[4];
    expPriv = st[5];
    st[7:6] = old;
    if (idx == 1) st[15:8] = progInd;
    expRf[{tgt, 2'b01}] = st;
    expRf[{tgt, 2'b10}] = 32'(idx);
    check(lat == 4, "R10 done latency", 64'(lat), 64'(4));
    check(curState == expState, "R7 new state", 64'(curState), 64'(expState));
    check(pendingFlags == expFlags, "R7 R3 flag after service", 64'(pendingFlags), 64'(expFlags));
    check(condCode == expCc && progMask == expPm, "R8 cc and program mask", 64'({condCode, progMask}), 64'({expCc, expPm}));
    check(protKey == expKey && decMode == expDec && privMode == expPriv, "R8 key dec priv",
          64'({protKey, decMode, privMode}), 64'({expKey, expDec, expPriv}));
    check(rf[{old, 2'b00}] == expRf[{old, 2'b00}], "R6 saved counter word", 64'(rf[{old, 2'b00}]), 64'(expRf[{old, 2'b00}]));
    check(rf[{tgt, 2'b01}] == expRf[{tgt, 2'b01}], "R9 status write-back", 64'(rf[{tgt, 2'b01}]), 64'(expRf[{tgt, 2'b01}]));
    check(rf[{tgt, 2'b10}] == expRf[{tgt, 2'b10}], "R10 register 15 weight", 64'(rf[{tgt, 2'b10}]), 64'(expRf[{tgt, 2'b10}]));
    @(negedge clk);
    check(seqDone == 1'b0, "R10 done is one cycle", 64'(seqDone), 64'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin
      rf[i] = $urandom;
      expRf[i] = rf[i];
    end
    rf[4'b1000][29:26] = 4'b0101;
    expRf[4'b1000] = rf[4'b1000];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(curState == 2'd0 && progMask == 4'hF && condCode == 2'd0, "R1 reset state and masks",
          64'({curState, progMask, condCode}), 64'({2'd0, 4'hF, 2'd0}));
    check(protKey == 4'h0 && !decMode && !privMode && pendingFlags == '0 && !seqDone && !rfWe,
          "R1 reset registers idle", 64'({protKey, decMode, privMode, pendingFlags, seqDone, rfWe}), 64'(0));

    // Enter P3 so the program mask becomes 4'b0101
    curIntMask = '1;
    reqDrive(16'h0100);
    service(1'b0, '0);
    // R2: causes 4 and 6 are cancelled
    reqDrive(16'h0078);
    check(pendingFlags == 16'h0028, "R2 cancelled program requests", 64'(pendingFlags), 64'h28);
    // R4: fully masked, then released one cause at a time
    curIntMask = '0;
    service(1'b0, '0);
    curIntMask = 16'h0020;
    service(1'b0, '0);
    curIntMask = '1;
    service(1'b0, '0);
    // R5: machine check taken past a zero mask, goes to P4 with indicators
    curIntMask = '0;
    reqDrive(16'h0802);
    service(1'b0, '0);
    check(curState == 2'd3, "R5 R7 machine check reaches P4", 64'(curState), 64'd3);
    // R3: new request during clear of the same cause
    curIntMask = '1;
    reqDrive(16'h0200);
    service(1'b0, 16'h0200);
    service(1'b0, '0);
    service(1'b0, '0);
    // R5: boundary held, two pending, exactly one taken
    reqDrive(16'h0500);
    service(1'b1, '0);
    repeat (4) begin
      @(negedge clk);
      check(seqDone == 1'b0, "R5 no second acceptance", 64'(seqDone), 64'(0));
    end
    check(pendingFlags == expFlags, "R5 second cause still pending", 64'(pendingFlags), 64'(expFlags));
    service(1'b0, '0);

    for (int n = 0; n < 150; n++) begin
      reqDrive(16'($urandom & $urandom & $urandom));
      curIntMask = 16'($urandom);
      service(1'b0, '0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule